// File: doc/BRIEF.md
# Configurable Registered Command Buffer with Cascadable Parity

This block registers the address and command lines of a registered memory module. On every rising clock edge it captures a word of data inputs. It drives registered copies of that word, but only when a chip select is active. Two strap inputs, held static while the block runs, choose between two layouts. The first is a wide layout with one output for each input. The second is a narrow fan-out layout in which each input feeds two output copies. In the fan-out layout the device is either the first or the second register of a pair on the module.

An even-parity checker covers the module-independent subset of the data inputs together with a parity bit from the controller. The checker result is registered one cycle behind the data outputs. An error is shown on an active-low flag. A combinational partial-parity output and a partial-parity input let two fan-out devices combine their checks. The first device passes its term to the second. The second device reports the error for the pair.

Straps `strap[1:0]` select the layout as follows:

- `2'b00` or `2'b10`: wide layout (TOPO_WIDE)
- `2'b01`: fan-out layout, first device (TOPO_FAN_A)
- `2'b11`: fan-out layout, second device (TOPO_FAN_B)

The strap decoder is a purely combinational selector with no transitions. The straps may change only while reset is asserted.

Top module: `cmd_reg_par`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros, `err_n` is 1 and `ppo` is 0.
- R2: In the wide layout, with at least one `cs_n` bit low at a rising edge, `q[24:0]` takes `d[24:0]` at that edge and `q[27:25]` stays 0.
- R3: In either fan-out layout, with a chip select active, `q[13:0]` and `q[27:14]` both take `d[13:0]`; `d[24:14]` has no effect on `q`.
- R4: When `cs_n` is `2'b11` at a rising edge, `q` keeps its previous value.
- R5: In the wide layout, `err_n` after edge k+1 is 0 exactly when `d[21:0]` and `par_in` sampled at edge k hold an odd number of ones; otherwise it is 1.
- R6: The parity capture and the error flag operate whatever the chip-select state.
- R7: After each edge, `ppo` shows the XOR of the captured parity-covered bits: `d[21:0]` and `par_in` in the wide layout, `d[10:0]` and `par_in` for the first device, and `d[10:0]` alone for the second device.
- R8: The first fan-out device (TOPO_FAN_A) keeps `err_n` at 1.
- R9: The second fan-out device (TOPO_FAN_B) drives `err_n` to 0 after edge k+1 exactly when the ones in its `d[10:0]` captured at edge k, plus `ppi` sampled at edge k+1, total an odd count. Its `par_in` is ignored.
- R10: `ppi` has no effect on `err_n` in the wide layout or in the first fan-out device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap | input | 2 | Static layout and role select |
| cs_n | input | 2 | Chip selects, active low; either one enables the output update |
| d | input | 25 | Data inputs |
| par_in | input | 1 | Parity bit from the controller |
| ppi | input | 1 | Partial parity from the upstream device |
| q | output | 28 | Registered data outputs |
| err_n | output | 1 | Parity error flag, 0 means error |
| ppo | output | 1 | Partial parity term for the downstream device |

## Verification
Output gating and parity checking can act in the same cycle. A word with an odd count of ones can arrive while both chip selects are high. The bench provokes this on purpose. It then expects `q` to hold its old value while `err_n` still drops one cycle later. In the second-device role, the captured-data term and a changing `ppi` meet in the same error stage. The reference model combines the two on every clock to judge the flag.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    typedef enum logic [1:0] {
        TOPO_WIDE  = 2'd0,
        TOPO_FAN_A = 2'd1,
        TOPO_FAN_B = 2'd2
    } topo_e;
endpackage

// File: rtl/cmdreg_cfg_decode.sv
module cmdreg_cfg_decode
    import cmdreg_pkg::*;
(
    input  logic [1:0] strap,
    output topo_e      topo
);
    // Bit 0 picks fan-out; bit 1 then picks the second-device role.
    always_comb begin
        unique case (strap)
            2'b01:   topo = TOPO_FAN_A;
            2'b11:   topo = TOPO_FAN_B;
            default: topo = TOPO_WIDE;
        endcase
    end
endmodule

// File: rtl/cmdreg_capture.sv
module cmdreg_capture
    import cmdreg_pkg::*;
#(
    parameter int IN_W  = 25,
    parameter int NAR_W = 14,
    parameter int OUT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  topo_e            topo,
    input  logic [1:0]       cs_n,
    input  logic [IN_W-1:0]  d,
    output logic [OUT_W-1:0] q
);
    localparam int FAN = 2;

    logic [FAN*NAR_W-1:0] fan_vec;
    logic [OUT_W-1:0]     q_next;
    logic                 load;

    // One copy of the narrow input field for every output group.
    for (genvar g = 0; g < FAN; g++) begin : g_copy
        assign fan_vec[g*NAR_W +: NAR_W] = d[NAR_W-1:0];
    end

    assign load = ~&cs_n;

    always_comb begin
        q_next = '0;
        unique case (topo)
            TOPO_WIDE:              q_next[IN_W-1:0]      = d;
            TOPO_FAN_A, TOPO_FAN_B: q_next[FAN*NAR_W-1:0] = fan_vec;
            default:                q_next                = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= q_next;
    end

    a_r4_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == 2'b11) |=> $stable(q));

    a_r3_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
        (topo != TOPO_WIDE) |-> (q[2*NAR_W-1:NAR_W] == q[NAR_W-1:0]));

    a_r2_spare_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (topo == TOPO_WIDE) |-> (q[OUT_W-1:IN_W] == '0));
endmodule

// File: rtl/cmdreg_parity.sv
module cmdreg_parity
    import cmdreg_pkg::*;
#(
    parameter int WIDE_PAR = 22,
    parameter int NAR_PAR  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  topo_e               topo,
    input  logic [WIDE_PAR-1:0] pbits,
    input  logic                par_in,
    input  logic                ppi,
    output logic                err_n,
    output logic                ppo
);
    logic [WIDE_PAR-1:0] cap_bits;
    logic                cap_par;
    logic                part;

    // Stage 1: capture the covered inputs on every edge, regardless of chip select.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_bits <= '0;
            cap_par  <= 1'b0;
        end else begin
            cap_bits <= pbits;
            cap_par  <= par_in;
        end
    end

    always_comb begin
        unique case (topo)
            TOPO_WIDE:  part = ^cap_bits ^ cap_par;
            TOPO_FAN_A: part = ^cap_bits[NAR_PAR-1:0] ^ cap_par;
            TOPO_FAN_B: part = ^cap_bits[NAR_PAR-1:0];
            default:    part = 1'b0;
        endcase
    end

    assign ppo = part;

    // Stage 2: error decision; the second device folds in the upstream term here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_n <= 1'b1;
        end else begin
            unique case (topo)
                TOPO_WIDE:  err_n <= ~part;
                TOPO_FAN_A: err_n <= 1'b1;
                TOPO_FAN_B: err_n <= ~(part ^ ppi);
                default:    err_n <= 1'b1;
            endcase
        end
    end

    a_r8_first_device_released: assert property (@(posedge clk) disable iff (!rst_n)
        (topo == TOPO_FAN_A) |=> err_n);

    a_r5_wide_flag_follows_term: assert property (@(posedge clk) disable iff (!rst_n)
        (topo == TOPO_WIDE) |=> (err_n == !$past(ppo)));

    a_r9_second_device_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        (topo == TOPO_FAN_B) |=> (err_n == !($past(ppo) ^ $past(ppi))));
endmodule

// File: rtl/cmd_reg_par.sv
module cmd_reg_par
    import cmdreg_pkg::*;
#(
    parameter int IN_W     = 25,
    parameter int NAR_W    = 14,
    parameter int WIDE_PAR = 22,
    parameter int NAR_PAR  = 11,
    localparam int OUT_W   = (2*NAR_W > IN_W) ? 2*NAR_W : IN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap,
    input  logic [1:0]       cs_n,
    input  logic [IN_W-1:0]  d,
    input  logic             par_in,
    input  logic             ppi,
    output logic [OUT_W-1:0] q,
    output logic             err_n,
    output logic             ppo
);
    topo_e topo;

    cmdreg_cfg_decode u_decode (
        .strap (strap),
        .topo  (topo)
    );

    cmdreg_capture #(
        .IN_W  (IN_W),
        .NAR_W (NAR_W),
        .OUT_W (OUT_W)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .topo  (topo),
        .cs_n  (cs_n),
        .d     (d),
        .q     (q)
    );

    cmdreg_parity #(
        .WIDE_PAR (WIDE_PAR),
        .NAR_PAR  (NAR_PAR)
    ) u_parity (
        .clk    (clk),
        .rst_n  (rst_n),
        .topo   (topo),
        .pbits  (d[WIDE_PAR-1:0]),
        .par_in (par_in),
        .ppi    (ppi),
        .err_n  (err_n),
        .ppo    (ppo)
    );
endmodule

// File: tb/cmd_reg_par_tb.sv
module cmd_reg_par_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap = 2'b00;
    logic [1:0]  cs_n = 2'b11;
    logic [24:0] d = '0;
    logic        par_in = 1'b0;
    logic        ppi = 1'b0;
    logic [27:0] q;
    logic        err_n;
    logic        ppo;

    int    errors = 0;
    int    checks = 0;
    int    md = 0;        // 0 wide, 1 first device, 2 second device
    string phase = "R1";

    logic [27:0] m_q;
    logic        m_err;
    logic [21:0] m_bits;
    logic        m_par;

    cmd_reg_par u_dut (
        .clk(clk), .rst_n(rst_n), .strap(strap), .cs_n(cs_n), .d(d),
        .par_in(par_in), .ppi(ppi), .q(q), .err_n(err_n), .ppo(ppo)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic odd_ones(input logic [21:0] v, input int n);
        int cnt = 0;
        for (int i = 0; i < n; i++) if (v[i]) cnt++;
        return (cnt % 2) == 1;
    endfunction

    function automatic logic model_ppo();
        if (md == 0) return odd_ones(m_bits, 22) ^ m_par;
        if (md == 1) return odd_ones(m_bits, 11) ^ m_par;
        return odd_ones(m_bits, 11);
    endfunction

    // Reference model, updated on the same edges as the design.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q = '0; m_err = 1'b1; m_bits = '0; m_par = 1'b0;
        end else begin
            if (md == 0)      m_err = !model_ppo();
            else if (md == 1) m_err = 1'b1;
            else              m_err = !(model_ppo() ^ ppi);
            m_bits = d[21:0];
            m_par  = par_in;
            if (cs_n != 2'b11) begin
                if (md == 0) m_q = {3'b000, d};
                else         m_q = {d[13:0], d[13:0]};
            end
        end
    end

    task automatic cmp(input string what, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    task automatic check_all();
        cmp("q", q, m_q);
        cmp("err_n", {27'd0, err_n}, {27'd0, m_err});
        cmp("ppo", {27'd0, ppo}, {27'd0, model_ppo()});
    endtask

    task automatic step(input logic [24:0] dv, input logic pv, input logic [1:0] cv, input logic iv);
        @(negedge clk);
        check_all();
        d = dv; par_in = pv; cs_n = cv; ppi = iv;
    endtask

    task automatic restart(input logic [1:0] s, input int mode);
        @(negedge clk);
        rst_n = 1'b0; strap = s; md = mode;
        d = '0; par_in = 1'b0; cs_n = 2'b11; ppi = 1'b0;
        @(negedge clk);
        phase = "R1";
        cmp("q", q, 28'd0);
        cmp("err_n", {27'd0, err_n}, 28'd1);
        cmp("ppo", {27'd0, ppo}, 28'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Wide layout: data, gating, flag timing
        restart(2'b00, 0);
        phase = "R2_R5_R7";
        step(25'h1FFFFFF, 1'b0, 2'b10, 1'b0);
        step(25'h0000001, 1'b1, 2'b01, 1'b0);
        step(25'h0000001, 1'b0, 2'b00, 1'b0);
        step(25'h1555555, 1'b1, 2'b10, 1'b0);
        for (int i = 0; i < 40; i++) step(25'($urandom), 1'($urandom), 2'b10, 1'b0);
        phase = "R4_R6";
        step(25'h0ABCDEF, 1'b0, 2'b11, 1'b0);
        step(25'h0000007, 1'b0, 2'b11, 1'b0);
        step(25'h1234567, 1'b1, 2'b11, 1'b0);
        for (int i = 0; i < 20; i++) step(25'($urandom), 1'($urandom), 2'($urandom), 1'b0);
        phase = "R10_wide";
        for (int i = 0; i < 20; i++) step(25'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
        step('0, 1'b0, 2'b10, 1'b0);

        // Wide again, selected through the other wide strap code
        restart(2'b10, 0);
        phase = "R2_alt_strap";
        for (int i = 0; i < 10; i++) step(25'($urandom), 1'($urandom), 2'b01, 1'($urandom));
        step('0, 1'b0, 2'b10, 1'b0);

        // First fan-out device
        restart(2'b01, 1);
        phase = "R3_R8_R7";
        step(25'h1FFC000, 1'b0, 2'b01, 1'b1);
        step(25'h0000001, 1'b0, 2'b10, 1'b1);
        for (int i = 0; i < 30; i++) step(25'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
        phase = "R4_R10_first";
        step(25'h0003FFF, 1'b1, 2'b11, 1'b1);
        step(25'h0000003, 1'b0, 2'b11, 1'b0);
        step('0, 1'b0, 2'b10, 1'b0);

        // Second fan-out device, cascade input active
        restart(2'b11, 2);
        phase = "R9_R3_R7";
        step(25'h0000001, 1'b1, 2'b10, 1'b0);
        step(25'h0000001, 1'b0, 2'b10, 1'b1);
        step(25'h0000003, 1'b1, 2'b10, 1'b1);
        step(25'h0000800, 1'b0, 2'b10, 1'b0);
        for (int i = 0; i < 30; i++) step(25'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
        phase = "R9_R6_R4";
        step(25'h0000005, 1'b0, 2'b11, 1'b0);
        step(25'h0000001, 1'b0, 2'b11, 1'b0);
        step('0, 1'b0, 2'b11, 1'b1);
        step('0, 1'b0, 2'b01, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule